// File: doc/BRIEF.md
# Doorbell Interrupt Mailbox

This block is the register-level core of an inter-agent doorbell scheme. One local agent rings up to eleven peer agents by writing a trigger word. Each set bit becomes a single-cycle pulse on that peer's trigger line. In the other direction, doorbell level inputs from the peers latch into a sticky status word. Software clears status bits by writing ones to them. A read-only mask decides which latched status bits reach the single combined interrupt line. The mask changes only through two strobe-style registers: one unmasks sources and the other masks them.

The eleven agents sit at sparse bit positions in every register word. The other bit positions are reserved. The status bits are also driven out on per-agent observation lines. A separate observation word samples 32 external level inputs so that software can read them. All accesses are full 32-bit words on a simple strobe bus. Read data is registered.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset the mask reads 0x0F0F0301, so every agent starts masked. Status, trigger, enable and disable all read 0. `irqOut`, `trigOut`, `obsOut` and `busRdata` are all 0.
- R2: Only bit positions 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27 are implemented (valid mask 0x0F0F0301). Agent index i (0 to 10) uses the i-th of these positions in ascending order. Every other bit reads as 0, and writes or doorbell inputs on it have no effect.
- R3: A write to byte offset 0x00 (trigger) sets `trigOut[i]` to write-data bit pos(i) for exactly the one cycle after the write edge. The trigger register always reads 0.
- R4: A high `doorbellIn` bit at a valid position sets the status bit at offset 0x10 on the next edge. The bit stays set until it is cleared through R5.
- R5: Writing to offset 0x10 clears each status bit written as 1 and leaves the others alone. If a doorbell sets the same bit in the same cycle, the bit stays set.
- R6: The mask at offset 0x14 is read-only. Writing to it leaves it unchanged.
- R7: Writing ones to offset 0x18 (enable) clears those mask bits. Writing ones to offset 0x1C (disable) sets them. Both offsets read 0.
- R8: `irqOut` is 1 exactly when some status bit is 1 while its mask bit is 0. It reflects a status or mask update from the cycle after the updating edge.
- R9: Offset 0x04 (observation) returns `observeIn` as sampled one edge earlier, restricted to the valid positions. Writes to it have no effect.
- R10: `obsOut[i]` equals status bit pos(i) at all times.
- R11: When `busRd` is high, `busRdata` takes the addressed word on that edge and holds it until the next read. The bus ignores accesses whose address bits [1:0] are not zero, and reads of such addresses or of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 5 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| doorbellIn | input | 32 | Incoming doorbell levels |
| observeIn | input | 32 | Levels sampled into the observation word |
| trigOut | output | 11 | Per-agent trigger pulses |
| obsOut | output | 11 | Per-agent copy of the status bits |
| irqOut | output | 1 | Combined interrupt |

## Verification
On every cycle the embedded assertions check the following. Trigger pulses occur only right after a trigger write. A status bit falls only on a status write. The mask moves only on an enable or disable write. Doorbells are never lost to a concurrent clear. Strobe-only offsets read zero. The interrupt is steady while its inputs are steady. The bench scenarios are the only evidence for the exact bit mapping of each agent, the reset values, the reserved-bit behaviour, observation sampling, read-data hold and the rejection of misaligned accesses. The bench sweeps every agent and every bit position for these.

// File: rtl/ipi_mbx_pkg.sv
package ipi_mbx_pkg;

  localparam int NUM_AGENTS = 11;
  localparam int DATA_W     = 32;

  // word indices (byte offset / 4) of each register
  localparam int WIDX_TRIG   = 0;
  localparam int WIDX_OBS    = 1;
  localparam int WIDX_STATUS = 4;
  localparam int WIDX_MASK   = 5;
  localparam int WIDX_ENABLE = 6;
  localparam int WIDX_DISABLE = 7;

  // bit position of agent i: groups of 1, 2, 4, 4 agents at bases 0, 8, 16, 24
  function automatic int agentPos(input int idx);
    if (idx < 1)      return idx;
    else if (idx < 3) return 8 + (idx - 1);
    else if (idx < 7) return 16 + (idx - 3);
    else              return 24 + (idx - 7);
  endfunction

  function automatic logic [DATA_W-1:0] validMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_AGENTS; i++) m[agentPos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] VALID_BITS = validMask();

  typedef enum logic [1:0] {
    RSEL_ZERO   = 2'd0,
    RSEL_OBS    = 2'd1,
    RSEL_STATUS = 2'd2,
    RSEL_MASK   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrTrig;
    logic   wrStatus;
    logic   wrEnable;
    logic   wrDisable;
    logic   rdEn;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/ipi_mbx_ctrl.sv
module ipi_mbx_ctrl
  import ipi_mbx_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strobes
);

  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] wordIdx;
  logic              wrOk;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrOk    = busWr && aligned;

  always_comb begin
    strobes           = '0;
    strobes.rdEn      = busRd;
    strobes.wrTrig    = wrOk && (wordIdx == WORD_W'(WIDX_TRIG));
    strobes.wrStatus  = wrOk && (wordIdx == WORD_W'(WIDX_STATUS));
    strobes.wrEnable  = wrOk && (wordIdx == WORD_W'(WIDX_ENABLE));
    strobes.wrDisable = wrOk && (wordIdx == WORD_W'(WIDX_DISABLE));
    strobes.rdSel     = RSEL_ZERO;
    if (aligned) begin
      if (wordIdx == WORD_W'(WIDX_OBS))         strobes.rdSel = RSEL_OBS;
      else if (wordIdx == WORD_W'(WIDX_STATUS)) strobes.rdSel = RSEL_STATUS;
      else if (wordIdx == WORD_W'(WIDX_MASK))   strobes.rdSel = RSEL_MASK;
    end
  end

  // R11: a misaligned access never produces a write strobe
  assert_misaligned_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr[1:0] != 2'b00) |->
      !(strobes.wrTrig || strobes.wrStatus || strobes.wrEnable || strobes.wrDisable));

  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.wrTrig, strobes.wrStatus, strobes.wrEnable, strobes.wrDisable}));

endmodule

// File: rtl/ipi_mbx_dpath.sv
module ipi_mbx_dpath
  import ipi_mbx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctlStrobe_t            strobes,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W-1:0]     doorbellIn,
  input  logic [DATA_W-1:0]     observeIn,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NUM_AGENTS-1:0] trigOut,
  output logic [NUM_AGENTS-1:0] obsOut,
  output logic                  irqOut
);

  logic [DATA_W-1:0]     wdataV;
  logic [DATA_W-1:0]     setV;
  logic [DATA_W-1:0]     statusQ, statusD;
  logic [DATA_W-1:0]     maskQ, maskD;
  logic [DATA_W-1:0]     obsQ;
  logic [DATA_W-1:0]     rdataQ, rdataD;
  logic [NUM_AGENTS-1:0] trigQ, trigD;

  assign wdataV = busWdata & VALID_BITS;
  assign setV   = doorbellIn & VALID_BITS;

  // status: clear first, then set, so a coincident doorbell wins
  always_comb begin
    statusD = statusQ;
    if (strobes.wrStatus) statusD = statusD & ~wdataV;
    statusD = statusD | setV;
  end

  always_comb begin
    maskD = maskQ;
    if (strobes.wrEnable)  maskD = maskD & ~wdataV;
    if (strobes.wrDisable) maskD = maskD | wdataV;
  end

  // per-agent mapping between sparse bit positions and dense pins
  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
    localparam int P = agentPos(g);
    assign trigD[g]  = strobes.wrTrig & busWdata[P];
    assign obsOut[g] = statusQ[P];
  end

  always_comb begin
    unique case (strobes.rdSel)
      RSEL_OBS:    rdataD = obsQ;
      RSEL_STATUS: rdataD = statusQ;
      RSEL_MASK:   rdataD = maskQ;
      default:     rdataD = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= '0;
      maskQ   <= VALID_BITS;
      obsQ    <= '0;
      trigQ   <= '0;
      rdataQ  <= '0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      obsQ    <= observeIn & VALID_BITS;
      trigQ   <= trigD;
      if (strobes.rdEn) rdataQ <= rdataD;
    end
  end

  assign trigOut  = trigQ;
  assign busRdata = rdataQ;
  assign irqOut   = |(statusQ & ~maskQ);

  // R3: a trigger pulse only follows a trigger write
  assert_trig_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trigOut != '0) |-> $past(strobes.wrTrig));

  // R4/R5: an incoming doorbell is never lost, even against a clear
  assert_doorbell_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (setV != '0) |=> ((statusQ & $past(setV)) == $past(setV)));

  // R4: status bits fall only on a status write
  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrStatus |=> (($past(statusQ) & ~statusQ) == '0));

  // R6/R7: mask moves only through enable or disable
  assert_mask_strobes_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.wrEnable || strobes.wrDisable) |=> $stable(maskQ));

  // R7: strobe-only offsets return zero
  assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rdEn && strobes.rdSel == RSEL_ZERO) |=> (busRdata == '0));

  // R8: the interrupt holds while nothing feeding it changes
  assert_irq_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(statusQ) && $stable(maskQ)) |-> $stable(irqOut));

  // R11: read data holds without a read strobe
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mbx_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [DATA_W-1:0]     doorbellIn,
  input  logic [DATA_W-1:0]     observeIn,
  output logic [NUM_AGENTS-1:0] trigOut,
  output logic [NUM_AGENTS-1:0] obsOut,
  output logic                  irqOut
);

  ctlStrobe_t strobes;

  ipi_mbx_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  ipi_mbx_dpath dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .busWdata   (busWdata),
    .doorbellIn (doorbellIn),
    .observeIn  (observeIn),
    .busRdata   (busRdata),
    .trigOut    (trigOut),
    .obsOut     (obsOut),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/ipi_mailbox_tb_top.sv
module ipi_mailbox_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        busWr, busRd;
  logic [4:0]  busAddr;
  logic [31:0] busWdata, busRdata, doorbellIn, observeIn;
  logic [10:0] trigOut, obsOut;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  ipi_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .doorbellIn(doorbellIn),
    .observeIn(observeIn), .trigOut(trigOut), .obsOut(obsOut), .irqOut(irqOut)
  );

  int bpos [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
  logic [31:0] validM;
  logic [31:0] expStatus, expMask;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  function automatic logic [10:0] denseOf(input logic [31:0] w);
    logic [10:0] r;
    for (int i = 0; i < 11; i++) r[i] = w[bpos[i]];
    return r;
  endfunction

  function automatic logic expIrq();
    return |(expStatus & ~expMask);
  endfunction

  task automatic checkState(input string req);
    logic [31:0] v;
    rd(5'h10, v); check(req, "status", v, expStatus);
    rd(5'h14, v); check(req, "mask", v, expMask);
    check(req, "irqOut", {31'b0, irqOut}, {31'b0, expIrq()});
    check("R10", "obsOut", {21'b0, obsOut}, {21'b0, denseOf(expStatus)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    validM = '0;
    foreach (bpos[i]) validM[bpos[i]] = 1'b1;
    rst_n = 1'b0; busWr = 0; busRd = 0; busAddr = '0; busWdata = '0;
    doorbellIn = '0; observeIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "rdata", busRdata, 32'h0);
    check("R1", "trigOut", {21'b0, trigOut}, 32'h0);
    check("R1", "obsOut", {21'b0, obsOut}, 32'h0);
    check("R1", "irqOut", {31'b0, irqOut}, 32'h0);
    rd(5'h14, v); check("R1", "mask", v, 32'h0F0F0301);
    rd(5'h10, v); check("R1", "status", v, 32'h0);
    rd(5'h00, v); check("R1", "trig read", v, 32'h0);
    expStatus = '0; expMask = 32'h0F0F0301;

    // R2/R7 every bit through enable then disable
    for (int b = 0; b < 32; b++) begin
      wr(5'h18, 32'h1 << b);
      expMask &= ~((32'h1 << b) & validM);
      rd(5'h14, v); check("R7", "mask after enable", v, expMask);
      check("R2", "reserved mask bits", v & ~validM, 32'h0);
    end
    rd(5'h18, v); check("R7", "enable read", v, 32'h0);
    rd(5'h1C, v); check("R7", "disable read", v, 32'h0);
    for (int b = 0; b < 32; b++) begin
      wr(5'h1C, 32'h1 << b);
      expMask |= (32'h1 << b) & validM;
      rd(5'h14, v); check("R7", "mask after disable", v, expMask);
    end

    // R3 trigger per agent, all-ones, reserved-only
    for (int i = 0; i < 11; i++) begin
      wr(5'h00, 32'h1 << bpos[i]);
      check("R3", "trig pulse", {21'b0, trigOut}, 32'h1 << i);
      @(negedge clk);
      check("R3", "trig end", {21'b0, trigOut}, 32'h0);
    end
    wr(5'h00, 32'hFFFF_FFFF);
    check("R3", "trig all", {21'b0, trigOut}, 32'h7FF);
    @(negedge clk);
    check("R3", "trig all end", {21'b0, trigOut}, 32'h0);
    wr(5'h00, ~validM);
    check("R2", "trig reserved", {21'b0, trigOut}, 32'h0);
    rd(5'h00, v); check("R3", "trig read", v, 32'h0);

    // R4/R5/R8 per agent doorbell life cycle
    for (int i = 0; i < 11; i++) begin
      doorbellIn = 32'h1 << bpos[i];
      @(negedge clk);
      doorbellIn = '0;
      expStatus |= 32'h1 << bpos[i];
      checkState("R4");
      wr(5'h18, 32'h1 << bpos[i]); expMask &= ~(32'h1 << bpos[i]);
      check("R8", "irq unmasked", {31'b0, irqOut}, 32'h1);
      wr(5'h10, 32'h1 << bpos[i]); expStatus &= ~(32'h1 << bpos[i]);
      check("R8", "irq after clear", {31'b0, irqOut}, 32'h0);
      checkState("R5");
      wr(5'h1C, 32'h1 << bpos[i]); expMask |= 32'h1 << bpos[i];
    end

    // R2 reserved doorbells
    doorbellIn = ~validM; @(negedge clk); doorbellIn = '0;
    checkState("R2");

    // R5 partial clear and set-wins
    doorbellIn = validM; @(negedge clk); doorbellIn = '0;
    expStatus = validM;
    wr(5'h10, 32'h0F00_0000); expStatus &= ~32'h0F00_0000;
    checkState("R5");
    doorbellIn = 32'h0000_0100;
    wr(5'h10, 32'h0000_0300);
    doorbellIn = '0;
    expStatus = (expStatus & ~32'h0000_0300) | 32'h0000_0100;
    checkState("R5");

    // R6 mask write ignored
    wr(5'h14, 32'h0); checkState("R6");
    wr(5'h18, 32'h0001_0000); expMask &= ~32'h0001_0000;
    checkState("R8");

    // R9 observation sampling
    for (int k = 0; k < 4; k++) begin
      observeIn = 32'hA5A5_A5A5 ^ (32'h1234_5678 * k);
      @(negedge clk);
      rd(5'h04, v); check("R9", "obs read", v, observeIn & validM);
    end
    wr(5'h04, 32'h0);
    rd(5'h04, v); check("R9", "obs after write", v, observeIn & validM);

    // R11 misaligned, unmapped, hold
    wr(5'h19, 32'hFFFF_FFFF); checkState("R11");
    wr(5'h1E, 32'hFFFF_FFFF); checkState("R11");
    rd(5'h08, v); check("R11", "unmapped read", v, 32'h0);
    rd(5'h15, v); check("R11", "misaligned read", v, 32'h0);
    rd(5'h14, v);
    wr(5'h10, 32'h0); @(negedge clk);
    check("R11", "rdata hold", busRdata, expMask);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule